// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It pairs per-address state with the outcomes of the last two resolved branches, whatever branch produced them. A shift register holds those two outcomes. Four bits of the fetch address select one of sixteen slots. Each slot holds four 2-bit saturating counters, and the current history picks one of them. The MSB of that counter is the prediction.

Lookup is combinational: a fetch address presented on the predict side returns a direction in the same cycle, together with the history value that was used. The pipeline keeps that history with the branch and hands it back on resolution. Training then touches exactly the counter that made the prediction, even if the live history has moved on since. Every resolution also shifts its actual outcome into the live history.

Top module: `corr_bpred`

## Requirements
- R1: After synchronous reset, the history output reads 00 and every counter holds 01 (weakly not taken). Every address therefore predicts not taken until it is trained.
- R2: The counter is selected by address bits [5:2] together with the current 2-bit history. Address bits outside [5:2] do not affect selection, so addresses that agree in [5:2] share counters.
- R3: `pred_taken` is the MSB of the selected counter (1 = taken). It is a combinational function of `pred_pc` and the current history, valid in the same cycle.
- R4: A resolution with outcome taken (1) increments the addressed counter and saturates at 11. Outcome not taken (0) decrements it and saturates at 00.
- R5: From a strong state (00 or 11), one contrary outcome does not change the predicted direction. A second consecutive contrary outcome does.
- R6: A resolution trains only the counter at {`upd_pc[5:2]`, `upd_hist`}, using the supplied history and not the current one. All other 63 counters keep their values.
- R7: Each resolution shifts the history left by one and places the outcome in bit 0, so bit 0 is the newest outcome and bit 1 the older. For example, not taken then taken gives 01. Without a resolution the history holds.
- R8: If a prediction and a resolution hit the same counter in one cycle, the prediction shows the value from before the update. The trained value is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | 32 | Fetch address to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | 2 | History used for this prediction, kept by the pipeline for the update |
| upd_valid | input | 1 | A branch resolved this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_hist | input | 2 | History captured when this branch was predicted |

## Verification
A counter trained at the wrong index, or with the wrong step, appears at the ports only when that address is predicted under the same history. Until then it stays hidden, so the bench moves the live history to the value under test before each probe. A counter that moved one step off its expected value can still agree in MSB, so a wrong value may show only one or two updates later, when a saturation or hysteresis boundary is crossed. A faulty history shift appears on `pred_hist` one cycle after the resolution.

// File: rtl/bp_pkg.sv
package bp_pkg;
    localparam int PC_W     = 32;
    localparam int IDX_LSB  = 2;
    localparam int SLOT_W   = 4;
    localparam int HIST_W   = 2;
    localparam int CTR_W    = 2;
    localparam int ENTRY_W  = SLOT_W + HIST_W;
    localparam int ENTRIES  = 1 << ENTRY_W;

    typedef logic [PC_W-1:0]    pc_t;
    typedef logic [HIST_W-1:0]  hist_t;
    typedef logic [CTR_W-1:0]   ctr_t;
    typedef logic [ENTRY_W-1:0] entry_idx_t;

    localparam ctr_t CTR_MAX   = '1;
    localparam ctr_t CTR_MIN   = '0;
    localparam ctr_t CTR_RESET = ctr_t'(1 << (CTR_W - 2));

    typedef struct packed {
        logic       valid;
        pc_t        pc;
        logic       taken;
        hist_t      hist;
    } resolve_t;

    function automatic entry_idx_t make_index(pc_t pc, hist_t h);
        return {pc[IDX_LSB +: SLOT_W], h};
    endfunction

    function automatic ctr_t ctr_train(ctr_t c, logic taken);
        if (taken)
            return (c == CTR_MAX) ? c : c + ctr_t'(1);
        else
            return (c == CTR_MIN) ? c : c - ctr_t'(1);
    endfunction
endpackage

// File: rtl/bp_hist_reg.sv
module bp_hist_reg
    import bp_pkg::*;
#(
    parameter int W = HIST_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         outcome,
    output logic [W-1:0] hist_q
);
    always_ff @(posedge clk) begin
        if (rst)
            hist_q <= '0;
        else if (shift_en)
            hist_q <= {hist_q[W-2:0], outcome};
    end

    assert_hist_newest_R7: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> hist_q[0] == $past(outcome));
    assert_hist_age_R7: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> hist_q[W-1:1] == $past(hist_q[W-2:0]));
    assert_hist_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(hist_q));
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
    import bp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  entry_idx_t rd_idx,
    output ctr_t       rd_ctr,
    input  logic       wr_en,
    input  entry_idx_t wr_idx,
    input  logic       wr_taken
);
    ctr_t ctr_q [ENTRIES];
    ctr_t wr_old;

    assign rd_ctr = ctr_q[rd_idx];
    assign wr_old = ctr_q[wr_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++)
                ctr_q[i] <= CTR_RESET;
        end else if (wr_en) begin
            ctr_q[wr_idx] <= ctr_train(wr_old, wr_taken);
        end
    end

    assert_sat_high_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_taken && wr_old == CTR_MAX |=> ctr_q[$past(wr_idx)] == CTR_MAX);
    assert_sat_low_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en && !wr_taken && wr_old == CTR_MIN |=> ctr_q[$past(wr_idx)] == CTR_MIN);
    assert_strong_taken_holds_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en && !wr_taken && wr_old == CTR_MAX |=> ctr_q[$past(wr_idx)][CTR_W-1]);
    assert_strong_not_holds_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_taken && wr_old == CTR_MIN |=> !ctr_q[$past(wr_idx)][CTR_W-1]);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_iso
        assert_untouched_R6: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_idx == entry_idx_t'(g)) |=> $stable(ctr_q[g]));
    end
endmodule

// File: rtl/corr_bpred.sv
module corr_bpred
    import bp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PC_W-1:0]   pred_pc,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_hist,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic              upd_taken,
    input  logic [HIST_W-1:0] upd_hist
);
    resolve_t   res;
    hist_t      live_hist;
    ctr_t       sel_ctr;
    entry_idx_t rd_idx;
    entry_idx_t wr_idx;

    assign res = '{valid: upd_valid, pc: upd_pc, taken: upd_taken, hist: upd_hist};

    bp_hist_reg #(.W(HIST_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (res.valid),
        .outcome  (res.taken),
        .hist_q   (live_hist)
    );

    assign rd_idx = make_index(pred_pc, live_hist);
    assign wr_idx = make_index(res.pc, res.hist);

    bp_ctr_table u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (rd_idx),
        .rd_ctr   (sel_ctr),
        .wr_en    (res.valid),
        .wr_idx   (wr_idx),
        .wr_taken (res.taken)
    );

    assign pred_taken = sel_ctr[CTR_W-1];
    assign pred_hist  = live_hist;

    assert_reset_not_taken_R1: assert property (@(posedge clk)
        rst |=> !pred_taken && pred_hist == '0);
    assert_known_pred_R3: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(pred_pc) |-> !$isunknown(pred_taken));
endmodule

// File: tb/tb_corr_bpred.sv
`timescale 1ns/1ps
module tb_corr_bpred;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] pred_pc;
    logic        pred_taken;
    logic [1:0]  pred_hist;
    logic        upd_valid;
    logic [31:0] upd_pc;
    logic        upd_taken;
    logic [1:0]  upd_hist;

    always #2.5 clk = ~clk;

    corr_bpred dut (
        .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_hist(upd_hist)
    );

    int checks = 0;
    int errors = 0;
    logic [1:0] m_ctr [64];
    logic [1:0] m_hist;

    localparam logic [31:0] PC_A   = 32'h0000_0024;   // slot 9
    localparam logic [31:0] PC_A2  = 32'hFFFF_FFE4;   // slot 9, other high bits
    localparam logic [31:0] PC_AUX = 32'h0000_003C;   // slot 15

    // {pc, taken}
    localparam logic [32:0] VEC [16] = '{
        {32'h0000_1000, 1'b1}, {32'h0000_1000, 1'b1}, {32'h0000_2004, 1'b0},
        {32'h0000_1000, 1'b1}, {32'h0000_1000, 1'b0}, {32'h0000_3008, 1'b1},
        {32'h0000_3008, 1'b1}, {32'h0000_3008, 1'b1}, {32'h0000_1000, 1'b1},
        {32'h0000_2004, 1'b0}, {32'hABCD_1040, 1'b1}, {32'h0000_1000, 1'b0},
        {32'h0000_3008, 1'b0}, {32'h0000_3008, 1'b0}, {32'h0000_1000, 1'b1},
        {32'h0000_2004, 1'b1}
    };

    function automatic int ix(logic [31:0] pc, logic [1:0] h);
        return int'({pc[5:2], h});
    endfunction

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_upd(logic [31:0] pc, logic t, logic [1:0] h);
        int k = ix(pc, h);
        if (t && m_ctr[k] != 2'b11) m_ctr[k] = m_ctr[k] + 2'd1;
        else if (!t && m_ctr[k] != 2'b00) m_ctr[k] = m_ctr[k] - 2'd1;
        m_hist = {m_hist[0], t};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; upd_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 64; i++) m_ctr[i] = 2'b01;
        m_hist = 2'b00;
    endtask

    // resolution with an explicit checkpoint history
    task automatic raw_upd(logic [31:0] pc, logic t, logic [1:0] h);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = t; upd_hist = h;
        @(posedge clk);
        model_upd(pc, t, h);
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic force_hist(logic [1:0] h);
        raw_upd(PC_AUX, h[1], 2'b00);
        raw_upd(PC_AUX, h[0], 2'b00);
    endtask

    task automatic peek(string req, logic [31:0] pc, logic exp);
        @(negedge clk);
        pred_pc = pc;
        #1;
        check(req, {1'b0, pred_taken}, {1'b0, exp});
    endtask

    // predict, check against model, then resolve with the returned history
    task automatic step(logic [31:0] pc, logic t);
        logic [1:0] h;
        @(negedge clk);
        upd_valid = 1'b0;
        pred_pc = pc;
        #1;
        check("R3 pred", {1'b0, pred_taken}, {1'b0, m_ctr[ix(pc, m_hist)][1]});
        check("R7 hist", pred_hist, m_hist);
        h = pred_hist;
        upd_valid = 1'b1; upd_pc = pc; upd_taken = t; upd_hist = h;
        @(posedge clk);
        model_upd(pc, t, h);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; upd_valid = 1'b0; pred_pc = '0; upd_pc = '0;
        upd_taken = 1'b0; upd_hist = '0;
        do_reset();

        // R1: reset state
        @(negedge clk);
        check("R1 hist", pred_hist, 2'b00);
        for (int s = 0; s < 16; s++) peek("R1 not taken", 32'(s << 2), 1'b0);

        // R3 R4 R7: vector walk against the model
        for (int v = 0; v < 16; v++) step(VEC[v][32:1], VEC[v][0]);
        @(negedge clk); upd_valid = 1'b0;
        #1 check("R7 after walk", pred_hist, m_hist);

        // R7: order of bits, hold without update
        do_reset();
        raw_upd(PC_AUX, 1'b0, 2'b00);
        raw_upd(PC_AUX, 1'b1, 2'b00);
        check("R7 01 order", pred_hist, 2'b01);
        repeat (3) @(negedge clk);
        check("R7 hold", pred_hist, 2'b01);

        // R4 R5 R6 R2: train slot 9 under checkpoint history 00
        do_reset();
        repeat (3) raw_upd(PC_A, 1'b1, 2'b00);     // 01->10->11->11
        force_hist(2'b00);
        peek("R4 up to taken", PC_A, 1'b1);
        peek("R2 alias same slot", PC_A2, 1'b1);
        force_hist(2'b01);
        peek("R6 sibling untouched", PC_A, 1'b0);
        raw_upd(PC_A, 1'b0, 2'b00);                 // 11->10
        force_hist(2'b00);
        peek("R5 one miss holds", PC_A, 1'b1);
        raw_upd(PC_A, 1'b0, 2'b00);                 // 10->01
        force_hist(2'b00);
        peek("R5 two misses flip", PC_A, 1'b0);
        repeat (3) raw_upd(PC_A, 1'b0, 2'b00);      // ->00
        raw_upd(PC_A, 1'b1, 2'b00);                 // 00->01
        force_hist(2'b00);
        peek("R4 floor", PC_A, 1'b0);
        raw_upd(PC_A, 1'b1, 2'b00);                 // 01->10
        force_hist(2'b00);
        peek("R4 climb", PC_A, 1'b1);

        // R6: supplied history, not live history, selects the trained counter
        do_reset();
        force_hist(2'b11);
        raw_upd(PC_A, 1'b1, 2'b10);                 // trains (9,10)
        force_hist(2'b11);
        peek("R6 live counter untouched", PC_A, 1'b0);
        force_hist(2'b10);
        peek("R6 checkpoint counter trained", PC_A, 1'b1);

        // R8: same-cycle collision
        do_reset();
        @(negedge clk);
        pred_pc = PC_A;
        upd_valid = 1'b1; upd_pc = PC_A; upd_taken = 1'b1; upd_hist = 2'b00;
        #1 check("R8 old value", {1'b0, pred_taken}, 2'b00);
        @(posedge clk);
        model_upd(PC_A, 1'b1, 2'b00);
        @(negedge clk); upd_valid = 1'b0;
        force_hist(2'b00);
        peek("R8 new value next", PC_A, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule